// File: doc/BRIEF.md
# Multiplexed LCD Segment/Common Driver

This block scans a four-common, half-bias multiplexed liquid-crystal panel. It holds no picture of its own. It reads a flat vector of display bits, one bit per pixel, where each bit names a segment line and a common line. For every common pin and every segment pin it produces a two-bit level code. An analog stage outside the block turns each code into the full supply, half supply or ground.

The commons are selected one at a time. Each selection lasts one time slot, and a slot is a fixed number of pulses of the `slot_tick` input. With a 1 kHz tick and the default of two pulses, a slot lasts 2 ms. A common that is not selected sits at the mid level. The selected common goes to one rail, and each segment pin goes to the other rail when its pixel is lit or to the same rail when it is dark. After every complete pass of the commons the drive polarity reverses, so each pixel sees no net DC.

When the display is disabled, every pin rests at the mid level. The same holds after reset, which also stands for a wake from a clock stop. Scanning then begins only after one full idle slot, starting from common 0 with positive polarity.

Top module: `lcd_mux_drv`

## Requirements
- R1: After reset, every common and segment code is mid (2'b01). Once `disp_en` is high, the outputs stay mid for one full idle slot, and scanning then starts at common 0 in phase 0.
- R2: While scanning, exactly one common is off the mid level. The selected common advances in the order 0, 1, 2, 3, 0, with one step per slot.
- R3: The level codes are 2'b10 for high supply, 2'b01 for mid and 2'b00 for ground. The code 2'b11 never appears on any output.
- R4: The pixel for segment s under common c is `disp_bits[s*4+c]`. While scanning, a lit pixel drives its segment to the rail opposite the selected common, and a dark pixel drives it to the same rail. A segment is never at mid while scanning. A change of `disp_bits` shows on the segment codes without waiting for a slot boundary.
- R5: In phase 0 the selected common is high (2'b10); in phase 1 it is ground (2'b00). The phase toggles each time the scan wraps from the last common back to common 0.
- R6: While `disp_en` is low, all outputs are mid from the next clock on. When `disp_en` rises again, the R1 start-up sequence repeats: one idle slot, then common 0 in phase 0.
- R7: A slot ends on the `TICKS_PER_SLOT`-th `slot_tick` pulse counted while enabled. Fewer pulses leave the selected common and the phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; also used on wake from clock stop |
| slot_tick | input | 1 | One-cycle timebase pulse |
| disp_en | input | 1 | Display enable; low forces all outputs to mid |
| disp_bits | input | 72 | Pixel bits, index s*4+c |
| com_lvl | output | 8 | Common level codes, common c at bits [2c+1:2c] |
| seg_lvl | output | 36 | Segment level codes, segment s at bits [2s+1:2s] |

## Verification
The assertions assume that `slot_tick` is a single-cycle pulse. They also assume that `disp_bits` may change at any time, and they therefore check only rail versus mid on segments, never a particular rail. The stimulus raises the tick for one cycle at a falling edge and lowers it at the next falling edge. It changes the enable and the pixel bits only between clock edges. It completes every slot it starts, so the bench's own count of ticks stays in step with the slot boundary.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_GND  = 2'b00;
  localparam lvl_t LVL_MID  = 2'b01;
  localparam lvl_t LVL_HIGH = 2'b10;

  // Rail taken by the selected common in the given phase.
  function automatic lvl_t sel_rail(input logic phase);
    return phase ? LVL_GND : LVL_HIGH;
  endfunction

  function automatic lvl_t other_rail(input lvl_t rail);
    return (rail == LVL_HIGH) ? LVL_GND : LVL_HIGH;
  endfunction

  function automatic lvl_t com_drive(input logic active, input logic selected,
                                     input logic phase);
    if (!active || !selected) return LVL_MID;
    return sel_rail(phase);
  endfunction

  function automatic lvl_t seg_drive(input logic active, input logic pixel,
                                     input logic phase);
    if (!active) return LVL_MID;
    return pixel ? other_rail(sel_rail(phase)) : sel_rail(phase);
  endfunction

endpackage

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer #(
  parameter int TICKS_PER_SLOT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_tick,
  input  logic disp_en,
  output logic slot_end
);
  localparam int CW = (TICKS_PER_SLOT > 1) ? $clog2(TICKS_PER_SLOT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SLOT - 1);

  logic [CW-1:0] cnt_q;

  assign slot_end = disp_en && slot_tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!disp_en) begin
      cnt_q <= '0;
    end else if (slot_tick) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq #(
  parameter int N_COM = 4,
  localparam int CIW = (N_COM > 1) ? $clog2(N_COM) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           disp_en,
  input  logic           slot_end,
  output logic           active,
  output logic [CIW-1:0] com_idx,
  output logic           phase
);
  localparam logic [CIW-1:0] LAST = CIW'(N_COM - 1);

  logic idle_q;

  assign active = !idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= 1'b1;
      com_idx <= '0;
      phase   <= 1'b0;
    end else if (!disp_en) begin
      idle_q  <= 1'b1;
      com_idx <= '0;
      phase   <= 1'b0;
    end else if (slot_end) begin
      if (idle_q) begin
        idle_q <= 1'b0;
      end else if (com_idx == LAST) begin
        com_idx <= '0;
        phase   <= ~phase;
      end else begin
        com_idx <= com_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_drv_pkg::*;
#(
  parameter int N_COM = 4,
  parameter int N_SEG = 18,
  localparam int CIW = (N_COM > 1) ? $clog2(N_COM) : 1
) (
  input  logic                   active,
  input  logic [CIW-1:0]         com_idx,
  input  logic                   phase,
  input  logic [N_COM*N_SEG-1:0] disp_bits,
  output logic [2*N_COM-1:0]     com_lvl,
  output logic [2*N_SEG-1:0]     seg_lvl
);
  for (genvar c = 0; c < N_COM; c++) begin : g_com
    assign com_lvl[2*c +: 2] = com_drive(active, com_idx == CIW'(c), phase);
  end

  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    logic [N_COM-1:0] px_row;
    assign px_row = disp_bits[s*N_COM +: N_COM];
    assign seg_lvl[2*s +: 2] = seg_drive(active, px_row[com_idx], phase);
  end
endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv #(
  parameter int N_COM          = 4,
  parameter int N_SEG          = 18,
  parameter int TICKS_PER_SLOT = 2,
  localparam int NPIX = N_COM * N_SEG,
  localparam int CIW  = (N_COM > 1) ? $clog2(N_COM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_tick,
  input  logic               disp_en,
  input  logic [NPIX-1:0]    disp_bits,
  output logic [2*N_COM-1:0] com_lvl,
  output logic [2*N_SEG-1:0] seg_lvl
);
  logic           slot_end;
  logic           active;
  logic [CIW-1:0] com_idx;
  logic           phase;

  lcd_slot_timer #(.TICKS_PER_SLOT(TICKS_PER_SLOT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_tick(slot_tick),
    .disp_en  (disp_en),
    .slot_end (slot_end)
  );

  lcd_scan_seq #(.N_COM(N_COM)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .disp_en (disp_en),
    .slot_end(slot_end),
    .active  (active),
    .com_idx (com_idx),
    .phase   (phase)
  );

  lcd_level_map #(.N_COM(N_COM), .N_SEG(N_SEG)) u_map (
    .active   (active),
    .com_idx  (com_idx),
    .phase    (phase),
    .disp_bits(disp_bits),
    .com_lvl  (com_lvl),
    .seg_lvl  (seg_lvl)
  );
endmodule

// File: rtl/lcd_mux_drv_chk.sv
module lcd_mux_drv_chk
  import lcd_drv_pkg::*;
#(
  parameter int N_COM = 4,
  parameter int N_SEG = 18,
  localparam int CIW = (N_COM > 1) ? $clog2(N_COM) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               disp_en,
  input logic               slot_end,
  input logic               active,
  input logic [CIW-1:0]     com_idx,
  input logic               phase,
  input logic [2*N_COM-1:0] com_lvl,
  input logic [2*N_SEG-1:0] seg_lvl
);
  logic [N_COM-1:0] com_off_mid, com_bad;
  logic [N_SEG-1:0] seg_at_mid, seg_bad;

  always_comb begin
    for (int c = 0; c < N_COM; c++) begin
      com_off_mid[c] = com_lvl[2*c +: 2] != LVL_MID;
      com_bad[c]     = com_lvl[2*c +: 2] == 2'b11;
    end
    for (int s = 0; s < N_SEG; s++) begin
      seg_at_mid[s] = seg_lvl[2*s +: 2] == LVL_MID;
      seg_bad[s]    = seg_lvl[2*s +: 2] == 2'b11;
    end
  end

  a_r2_one_common: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> $countones(com_off_mid) == 1);

  a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && active && slot_end && com_idx != CIW'(N_COM-1))
      |=> com_idx == $past(com_idx) + 1'b1);

  a_r3_legal_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (com_bad == '0) && (seg_bad == '0));

  a_r4_seg_rails: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> seg_at_mid == '0);

  a_r5_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && active && slot_end && com_idx == CIW'(N_COM-1))
      |=> (phase != $past(phase)) && com_idx == '0);

  a_r1_start_com0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (com_idx == '0) && !phase);

  a_r6_idle_mid: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (com_off_mid == '0) && (seg_at_mid == '1));

  a_r6_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> !active);
endmodule

bind lcd_mux_drv lcd_mux_drv_chk #(.N_COM(N_COM), .N_SEG(N_SEG)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .disp_en (disp_en),
  .slot_end(slot_end),
  .active  (active),
  .com_idx (com_idx),
  .phase   (phase),
  .com_lvl (com_lvl),
  .seg_lvl (seg_lvl)
);

// File: tb/tb_lcd_mux_drv.sv
module tb_lcd_mux_drv;
  localparam int NC = 4;
  localparam int NS = 18;
  localparam int TK = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            slot_tick = 1'b0;
  logic            disp_en = 1'b0;
  logic [NC*NS-1:0] disp_bits = '0;
  logic [2*NC-1:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;

  int checks = 0;
  int errors = 0;

  // Bench model of the scan state
  bit b_act = 0;
  int b_com = 0;
  bit b_ph  = 0;

  always #5 clk = ~clk;

  lcd_mux_drv #(.N_COM(NC), .N_SEG(NS), .TICKS_PER_SLOT(TK)) dut (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .disp_en(disp_en),
    .disp_bits(disp_bits), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // Codes: 2'b10 high, 2'b01 mid, 2'b00 ground
  function automatic logic [1:0] want_com(int c);
    if (!b_act || c != b_com) return 2'b01;
    return b_ph ? 2'b00 : 2'b10;
  endfunction

  function automatic logic [1:0] want_seg(int s);
    logic lit;
    if (!b_act) return 2'b01;
    lit = disp_bits[s*NC + b_com];
    if (b_ph == 1'b0) return lit ? 2'b00 : 2'b10;
    return lit ? 2'b10 : 2'b00;
  endfunction

  task automatic check_outputs(string tag);
    bit bad = 0;
    checks++;
    for (int c = 0; c < NC; c++)
      if (!bad && com_lvl[2*c +: 2] !== want_com(c)) begin
        $display("FAIL %s: com%0d actual %b expected %b", tag, c, com_lvl[2*c +: 2], want_com(c));
        bad = 1;
      end
    for (int s = 0; s < NS; s++)
      if (!bad && seg_lvl[2*s +: 2] !== want_seg(s)) begin
        $display("FAIL %s: seg%0d actual %b expected %b", tag, s, seg_lvl[2*s +: 2], want_seg(s));
        bad = 1;
      end
    if (bad) errors++;
  endtask

  task automatic tick();
    @(negedge clk) slot_tick = 1'b1;
    @(negedge clk) slot_tick = 1'b0;
  endtask

  task automatic model_slot();
    if (!b_act) begin b_act = 1; b_com = 0; b_ph = 0; end
    else if (b_com == NC-1) begin b_com = 0; b_ph = ~b_ph; end
    else b_com++;
  endtask

  task automatic one_slot();
    for (int i = 0; i < TK; i++) tick();
    model_slot();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; disp_en = 1'b0;
    b_act = 0; b_com = 0; b_ph = 0;
    repeat (3) @(negedge clk);
    check_outputs("R1 reset mid");
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1 after reset release");
  endtask

  task automatic t_warmup();
    disp_bits = 72'h5A_A5F0_0FCC_33AA_5569;
    disp_en = 1'b1;
    @(negedge clk);
    check_outputs("R1 enabled, idle slot");
    for (int i = 0; i < TK-1; i++) tick();
    check_outputs("R7 idle slot not yet over");
    tick(); model_slot();
    check_outputs("R1 scan starts com0 phase0");
  endtask

  task automatic t_scan(int slots, string tag);
    for (int i = 0; i < slots; i++) begin
      disp_bits = {disp_bits[70:0], disp_bits[71] ^ disp_bits[5]};
      @(negedge clk);
      check_outputs("R4 pattern mid-slot");
      one_slot();
      check_outputs(tag);
    end
  endtask

  task automatic t_partial();
    for (int i = 0; i < TK-1; i++) tick();
    check_outputs("R7 partial slot holds common");
    tick(); model_slot();
    check_outputs("R7 full slot advances");
  endtask

  task automatic t_patterns();
    disp_bits = '1;
    @(negedge clk); check_outputs("R4 all lit");
    disp_bits = '0;
    @(negedge clk); check_outputs("R4 all dark");
    disp_bits = {18{4'b0001}};
    @(negedge clk); check_outputs("R4 column pattern");
  endtask

  task automatic t_disable();
    disp_en = 1'b0;
    b_act = 0; b_com = 0; b_ph = 0;
    @(negedge clk);
    check_outputs("R6 disabled mid");
    tick();
    check_outputs("R6 ticks ignored while disabled");
    disp_en = 1'b1;
    @(negedge clk);
    check_outputs("R6 re-enable idle");
    one_slot();
    check_outputs("R6 restart com0 phase0");
  endtask

  initial begin
    #2_000_000ns;
    $display("FAIL watchdog: actual timeout expected completion");
    errors++; checks++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_warmup();
    t_scan(NC, "R2 commons in order");
    t_scan(NC + 1, "R5 phase toggles after pass");
    t_patterns();
    t_partial();
    t_scan(2, "R3 codes after partial");
    t_disable();
    t_scan(3, "R2 scan after restart");
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule